// File: doc/BRIEF.md
# Transmit Completion Auto-Release Manager

This block sits between a CPU-fed queue of transmit packet numbers and the transmitter. It hands queued packet numbers to the transmitter one at a time, oldest first. When the transmitter reports that a packet finished, the block decides what happens to that packet. It can free the packet's memory pages through a release strobe to the page allocator, or it can record the packet number in a completion FIFO for the CPU to read. It also raises a transmit interrupt, raises a transmit-empty interrupt, or stops transmission, depending on the outcome.

A control input selects automatic release. When it is set, a packet that went out cleanly frees its pages at once and leaves no trace in the completion FIFO, so a run of packets interrupts only when it has fully drained. When it is clear, every finished packet is recorded for the CPU and no pages are freed by the block. A fatal error halts the sequence in both modes. The failed packet keeps its pages and its number is exposed, so the CPU can repair the cause and re-enable transmission.

Top module: `tx_autorel_mgr`

## Requirements
- R1: After reset, txen, tx_req, rel_vld, tx_int and txe_int are 0, cf_empty is 1 and cf_ovf is 0.
- R2: When txen is 1, no packet is in flight and the packet queue holds an entry, tx_req rises one cycle later with tx_pnum equal to the oldest queued number. Packets go out in the order they were pushed, and tx_pnum holds steady until tx_done.
- R3: A successful completion (tx_done=1, tx_ok=1) with auto_rel=1 produces a single-cycle rel_vld in the next cycle, carrying the finished packet number on rel_pnum, and writes nothing into the completion FIFO.
- R4: A successful completion with auto_rel=1 does not pulse tx_int. In either mode, txe_int pulses for one cycle after a successful completion only when no further packet is queued.
- R5: With auto_rel=0, every completion pushes the packet number into the completion FIFO, pulses tx_int in the next cycle and never asserts rel_vld.
- R6: A fatal completion (tx_done=1, tx_ok=0) in either mode does all of the following: it pulses tx_int, clears txen in the next cycle, places the packet number on fail_pnum, pushes it into the completion FIFO, asserts no rel_vld, and dispatches no further packet while txen stays 0.
- R7: A txen_set pulse sets txen, and transmission resumes with the next queued packet after the failed one.
- R8: The completion FIFO presents its oldest entry on cf_data. cf_pop removes that entry. cf_empty is 1 exactly when the FIFO holds nothing.
- R9: The completion FIFO holds 8 entries. A push while it is full is dropped without changing the stored entries and sets cf_ovf, which stays 1 until reset.
- R10: A tx_done pulse while no packet is in flight is ignored: it produces no rel_vld, tx_int or txe_int and no FIFO entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_rel | input | 1 | Automatic release of successful packets |
| txen_set | input | 1 | CPU pulse that sets the transmit enable flag |
| q_push | input | 1 | Enqueue a packet number |
| q_pnum | input | 6 | Packet number to enqueue |
| q_full | output | 1 | Packet queue is full |
| tx_req | output | 1 | A packet is handed to the transmitter |
| tx_pnum | output | 6 | Packet number in flight |
| tx_done | input | 1 | Transmitter finished the packet in flight |
| tx_ok | input | 1 | Completion outcome: 1 success, 0 fatal error |
| rel_vld | output | 1 | Single-cycle page release strobe |
| rel_pnum | output | 6 | Packet number whose pages are released |
| cf_pop | input | 1 | Remove the oldest completion entry |
| cf_data | output | 6 | Oldest completion entry |
| cf_empty | output | 1 | Completion FIFO is empty |
| cf_ovf | output | 1 | Sticky: a completion push was dropped |
| fail_pnum | output | 6 | Number of the last packet that failed |
| tx_int | output | 1 | Transmit interrupt pulse |
| txe_int | output | 1 | Transmit-empty interrupt pulse |
| txen | output | 1 | Transmit enable flag |

## Verification
The bench switches auto_rel between packets and compares each completion against a model of the queue and FIFO. A design that released pages in manual mode, or recorded successful packets in auto mode, would show a stray rel_vld or a non-empty FIFO. A design that fired txe_int in the middle of a run, or skipped it at the end, would miss the drained-queue check. After a fatal error the bench waits several cycles to confirm that nothing is dispatched and that no pages are freed, and then checks that the next packet goes out after re-enable. It also fills the completion FIFO, pushes one more entry, and confirms that the overflow is sticky and that the stored order is unchanged. It pulses tx_done with nothing in flight and confirms that nothing happens.

// File: rtl/tx_ar_pkg.sv
package tx_ar_pkg;
  typedef enum logic [1:0] {
    SQ_HALT = 2'd0,
    SQ_IDLE = 2'd1,
    SQ_BUSY = 2'd2
  } seq_st_e;
endpackage

// File: rtl/tx_ar_fifo.sv
module tx_ar_fifo #(
  parameter int W     = 6,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic wr_ok, rd_ok;

  assign wr_ok = push && !full;
  assign rd_ok = pop && !empty;
  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (rd_ok) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R9: a push into a full store without a pop leaves the occupancy unchanged
  assert_full_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(cnt));

  // R8: occupancy never exceeds the depth
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= (AW+1)'(DEPTH));
endmodule

// File: rtl/tx_ar_seq.sv
module tx_ar_seq
  import tx_ar_pkg::*;
#(
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          auto_rel,
  input  logic          txen_set,
  input  logic          q_empty,
  input  logic [PW-1:0] q_head,
  output logic          q_pop,
  input  logic          tx_done,
  input  logic          tx_ok,
  output logic          tx_req,
  output logic [PW-1:0] tx_pnum,
  output logic          rel_vld,
  output logic [PW-1:0] rel_pnum,
  output logic          cf_push,
  output logic [PW-1:0] cf_wdata,
  output logic [PW-1:0] fail_pnum,
  output logic          tx_int,
  output logic          txe_int,
  output logic          txen
);
  seq_st_e st;
  logic active;
  logic done_acc;

  always_comb begin
    if (!txen)       st = SQ_HALT;
    else if (active) st = SQ_BUSY;
    else             st = SQ_IDLE;
  end

  assign done_acc = tx_done && active;
  assign q_pop    = (st == SQ_IDLE) && !q_empty;
  assign cf_push  = done_acc && (!tx_ok || !auto_rel);
  assign cf_wdata = tx_pnum;
  assign tx_req   = active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      tx_pnum   <= '0;
      txen      <= 1'b0;
      rel_vld   <= 1'b0;
      rel_pnum  <= '0;
      fail_pnum <= '0;
      tx_int    <= 1'b0;
      txe_int   <= 1'b0;
    end else begin
      rel_vld <= 1'b0;
      tx_int  <= 1'b0;
      txe_int <= 1'b0;
      if (txen_set) txen <= 1'b1;
      if (q_pop) begin
        active  <= 1'b1;
        tx_pnum <= q_head;
      end
      if (done_acc) begin
        active <= 1'b0;
        if (tx_ok) begin
          txe_int <= q_empty;
          if (auto_rel) begin
            rel_vld  <= 1'b1;
            rel_pnum <= tx_pnum;
          end else begin
            tx_int <= 1'b1;
          end
        end else begin
          tx_int    <= 1'b1;
          txen      <= 1'b0;
          fail_pnum <= tx_pnum;
        end
      end
    end
  end

  // R3: a release strobe lasts one cycle
  assert_rel_single_R3: assert property (@(posedge clk) disable iff (rst)
    rel_vld |=> !rel_vld);

  // R5: manual mode never frees pages
  assert_no_rel_manual_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_done && tx_req && !auto_rel) |=> !rel_vld);

  // R6: a fatal completion drops the enable flag and frees nothing
  assert_fatal_halt_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_done && tx_req && !tx_ok) |=> (!txen && !rel_vld && tx_int));

  // R2: the packet in flight stays put until it completes
  assert_pnum_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !tx_done) |=> (tx_req && $stable(tx_pnum)));

  // R10: completion without a packet in flight has no effect
  assert_idle_done_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_done && !tx_req) |=> (!rel_vld && !tx_int && !txe_int));
endmodule

// File: rtl/tx_autorel_mgr.sv
module tx_autorel_mgr #(
  parameter int PW       = 6,
  parameter int Q_DEPTH  = 8,
  parameter int CF_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          auto_rel,
  input  logic          txen_set,
  input  logic          q_push,
  input  logic [PW-1:0] q_pnum,
  output logic          q_full,
  output logic          tx_req,
  output logic [PW-1:0] tx_pnum,
  input  logic          tx_done,
  input  logic          tx_ok,
  output logic          rel_vld,
  output logic [PW-1:0] rel_pnum,
  input  logic          cf_pop,
  output logic [PW-1:0] cf_data,
  output logic          cf_empty,
  output logic          cf_ovf,
  output logic [PW-1:0] fail_pnum,
  output logic          tx_int,
  output logic          txe_int,
  output logic          txen
);
  logic          q_empty, q_pop;
  logic [PW-1:0] q_head;
  logic          cf_push, cf_full;
  logic [PW-1:0] cf_wdata;

  tx_ar_fifo #(.W(PW), .DEPTH(Q_DEPTH)) u_pkt_q (
    .clk(clk), .rst(rst), .push(q_push), .wdata(q_pnum), .pop(q_pop),
    .rdata(q_head), .empty(q_empty), .full(q_full));

  tx_ar_seq #(.PW(PW)) u_seq (
    .clk(clk), .rst(rst), .auto_rel(auto_rel), .txen_set(txen_set),
    .q_empty(q_empty), .q_head(q_head), .q_pop(q_pop),
    .tx_done(tx_done), .tx_ok(tx_ok), .tx_req(tx_req), .tx_pnum(tx_pnum),
    .rel_vld(rel_vld), .rel_pnum(rel_pnum), .cf_push(cf_push),
    .cf_wdata(cf_wdata), .fail_pnum(fail_pnum), .tx_int(tx_int),
    .txe_int(txe_int), .txen(txen));

  tx_ar_fifo #(.W(PW), .DEPTH(CF_DEPTH)) u_cmp_q (
    .clk(clk), .rst(rst), .push(cf_push), .wdata(cf_wdata), .pop(cf_pop),
    .rdata(cf_data), .empty(cf_empty), .full(cf_full));

  always_ff @(posedge clk) begin
    if (rst) cf_ovf <= 1'b0;
    else if (cf_push && cf_full) cf_ovf <= 1'b1;
  end

  // R9: the overflow flag is sticky
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    cf_ovf |=> cf_ovf);
endmodule

// File: tb/tx_autorel_mgr_test.sv
module tx_autorel_mgr_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic auto_rel = 1'b0, txen_set = 1'b0, q_push = 1'b0, tx_done = 1'b0;
  logic tx_ok = 1'b0, cf_pop = 1'b0;
  logic [5:0] q_pnum = '0;
  logic q_full, tx_req, rel_vld, cf_empty, cf_ovf, tx_int, txe_int, txen;
  logic [5:0] tx_pnum, rel_pnum, cf_data, fail_pnum;

  int checks = 0, fails = 0;
  int qm[$];
  int cm[$];
  bit ovf_m = 0;

  always #2.5 clk = ~clk;

  tx_autorel_mgr uut (
    .clk(clk), .rst(rst), .auto_rel(auto_rel), .txen_set(txen_set),
    .q_push(q_push), .q_pnum(q_pnum), .q_full(q_full), .tx_req(tx_req),
    .tx_pnum(tx_pnum), .tx_done(tx_done), .tx_ok(tx_ok), .rel_vld(rel_vld),
    .rel_pnum(rel_pnum), .cf_pop(cf_pop), .cf_data(cf_data),
    .cf_empty(cf_empty), .cf_ovf(cf_ovf), .fail_pnum(fail_pnum),
    .tx_int(tx_int), .txe_int(txe_int), .txen(txen));

  task automatic chk(input bit good, input string req, input int act, input int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  task automatic push_pkt(input int p);
    q_pnum = 6'(p);
    q_push = 1'b1;
    @(negedge clk);
    q_push = 1'b0;
    qm.push_back(p);
  endtask

  task automatic enable();
    txen_set = 1'b1;
    @(negedge clk);
    txen_set = 1'b0;
    chk(txen == 1'b1, "R7 txen set", txen, 1);
  endtask

  function automatic bit exp_push(input bit ok, input bit ar);
    return !ok || !ar;
  endfunction

  // one packet completion, checked against the model
  task automatic complete(input bit ok);
    int p;
    bit seen = 0;
    bit ar;
    for (int i = 0; i < 20 && !seen; i++) begin
      if (tx_req) seen = 1; else @(negedge clk);
    end
    chk(seen, "R2 tx_req rises", tx_req, 1);
    if (!seen) return;
    p = qm[0];
    chk(tx_pnum == 6'(p), "R2 dispatch order", tx_pnum, p);
    ar = auto_rel;
    tx_ok = ok;
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    chk(rel_vld == (ok && ar), "R3 release strobe", rel_vld, ok && ar);
    if (ok && ar) chk(rel_pnum == 6'(p), "R3 release number", rel_pnum, p);
    chk(tx_int == exp_push(ok, ar), ok ? "R4/R5 tx_int" : "R6 tx_int", tx_int, exp_push(ok, ar));
    chk(txe_int == (ok && qm.size() == 1), "R4 txe_int", txe_int, ok && qm.size() == 1);
    void'(qm.pop_front());
    if (exp_push(ok, ar)) begin
      if (cm.size() < 8) cm.push_back(p); else ovf_m = 1;
    end
    chk(cf_empty == (cm.size() == 0), "R8 cf_empty", cf_empty, cm.size() == 0);
    chk(cf_ovf == ovf_m, "R9 cf_ovf", cf_ovf, ovf_m);
    if (cm.size() > 0) chk(cf_data == 6'(cm[0]), "R8 cf head", cf_data, cm[0]);
    if (!ok) begin
      chk(txen == 1'b0, "R6 txen cleared", txen, 0);
      chk(fail_pnum == 6'(p), "R6 fail_pnum", fail_pnum, p);
      repeat (3) @(negedge clk);
      chk(tx_req == 1'b0 && rel_vld == 1'b0, "R6 halted", tx_req, 0);
    end
  endtask

  task automatic pop_cf();
    chk(cf_data == 6'(cm[0]), "R8 pop data", cf_data, cm[0]);
    cf_pop = 1'b1;
    @(negedge clk);
    cf_pop = 1'b0;
    void'(cm.pop_front());
    chk(cf_empty == (cm.size() == 0), "R8 empty after pop", cf_empty, cm.size() == 0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7531);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!txen && !tx_req && !rel_vld && !tx_int && !txe_int, "R1 outputs idle", txen, 0);
    chk(cf_empty && !cf_ovf, "R1 fifo state", cf_empty, 1);

    // R10: stray completion with nothing in flight
    enable();
    tx_ok = 1'b1; tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    chk(!rel_vld && !tx_int && !txe_int && cf_empty, "R10 stray done ignored", rel_vld, 0);

    // directed auto-release run: txe only at the end
    auto_rel = 1'b1;
    push_pkt(5); push_pkt(17); push_pkt(42);
    complete(1); complete(1); complete(1);

    // directed fatal in auto mode, then resume with the next packet
    push_pkt(9); push_pkt(33);
    complete(0);
    enable();
    complete(1);

    // manual mode: every completion recorded
    auto_rel = 1'b0;
    push_pkt(1); push_pkt(2);
    complete(1); complete(0);
    enable();
    while (cm.size() > 0) pop_cf();

    // random mix
    for (int it = 0; it < 60; it++) begin
      int n;
      n = 1 + int'($urandom % 3);
      auto_rel = $urandom % 2;
      for (int k = 0; k < n && qm.size() < 8; k++) push_pkt(int'($urandom % 64));
      while (qm.size() > 0) begin
        bit ok;
        ok = ($urandom % 5) != 0;
        complete(ok);
        if (!ok) enable();
        if (cm.size() >= 6 || (cm.size() > 0 && $urandom % 2 == 1)) pop_cf();
      end
    end
    while (cm.size() > 0) pop_cf();

    // overflow: fill the completion FIFO and push one more
    auto_rel = 1'b0;
    for (int k = 0; k < 8; k++) push_pkt(10 + k);
    for (int k = 0; k < 8; k++) complete(1);
    chk(cf_ovf == 1'b0, "R9 no overflow at full", cf_ovf, 0);
    push_pkt(60);
    complete(1);
    chk(cf_ovf == 1'b1, "R9 overflow set", cf_ovf, 1);
    repeat (4) @(negedge clk);
    chk(cf_ovf == 1'b1, "R9 overflow sticky", cf_ovf, 1);
    while (cm.size() > 0) pop_cf();
    chk(cf_empty == 1'b1, "R9 dropped entry absent", cf_empty, 1);

    finish_run();
  end
endmodule